// File: doc/BRIEF.md
# SPI Serial EEPROM Target Front End

This block is a synchronous SPI target that behaves like a 512-byte serial EEPROM. It oversamples SCK, the active-low chip select and the serial input with its own system clock, using SPI mode 0. It assembles 8-bit instructions and the following low address byte and answers on the serial output. The ninth address bit travels in bit 3 of the READ and WRITE instruction bytes. Data is kept in an internal byte array that is written so that block RAM can be inferred.

Reads stream one byte after another and wrap from the last byte of the array to the first. Writes need a write-enable latch, and that latch is set only when chip select rises after a complete, lone enable instruction. Incoming write bytes go into a separate page-write engine. This engine holds one 16-byte page, wraps inside it, and copies the page into the array during a timed write cycle. While that cycle runs, a status read still works, but array reads return all ones.

Top module: `spi_ee_target`

## Requirements
- R1: Chip select low opens a transaction and chip select high closes it at any point. While closed, and during instruction and address bits, the output enable `spi_miso_oe` stays low. It rises only while read or status data is being shifted out.
- R2: READ is `0000_A011`, where instruction bit 3 is address bit 8, and it is followed by the low address byte. The addressed byte appears MSB first. Each bit changes after a falling SCK edge and is valid at the next rising edge. The first bit follows the falling edge after the 16th rising edge.
- R3: With continued clocks a read returns consecutive addresses, and after address 1FFh it returns 000h.
- R4: WREN (`0000_0110`) sets the write-enable latch only when chip select rises after exactly 8 bits. The latch stays clear if more clocks follow in the same transaction, such as a WRITE issued without first raising chip select.
- R5: WRITE is `0000_A010`, followed by the low address and data bytes. The array changes only if three conditions hold: the latch was set, at least one whole data byte arrived, and chip select rose on a byte boundary. In every other case the array is unchanged.
- R6: Write data stays inside the 16-byte page of the start address. After the page's last byte the next byte goes to the page's first byte, and a later byte to the same location overwrites an earlier one.
- R7: RDSR (`0000_0101`) returns a status byte, repeated while clocks continue. Bit 0 is write-in-progress, bit 1 is the write-enable latch, and bits 7..2 are zero.
- R8: During a write cycle (`WR_CYCLES` system clocks after the commit), any READ returns FFh for every byte of that transaction. WRITE, WREN and WRDI are ignored during the cycle, while RDSR is answered.
- R9: The write-enable latch clears when a write cycle ends. WRDI (`0000_0100`) clears it when chip select rises after exactly 8 bits.
- R10: An unrecognised instruction byte makes the block ignore the rest of the transaction. The output enable stays low and neither the array nor the latch changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | SPI serial clock (mode 0, idles low) |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_oe | output | 1 | Drive enable for spi_miso; low means high-impedance |

## Verification
The bench drives real SPI frames and compares each returned bit against a behavioural model of the array, the latch and the write-in-progress flag.

- **Page wrap:** a multi-byte write that starts near the end of the top page separates page-wrapped writes from linear writes.
- **Array rollover:** a long read starting at 1FCh separates wrap to 000h from wrap to the page start.
- **Write cycle:** status and array reads issued during the cycle separate a correct refusal from stale data, and a WRITE issued during the cycle must leave no trace.
- **Malformed frames:** WREN followed by extra clocks, WREN followed by a WRITE in one frame, a WRITE without the latch, a WRITE cut mid-byte, and an unknown opcode each check that a framing rule guards the latch or the array.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

  localparam int ADDR_W = 9;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [2:0] OP_READ_LO  = 3'b011;
  localparam logic [2:0] OP_WRITE_LO = 3'b010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_OPC,
    ST_RD_ADDR,
    ST_RD_DATA,
    ST_WR_ADDR,
    ST_WR_DATA,
    ST_STATUS,
    ST_WEN,
    ST_WDI,
    ST_IGNORE
  } fe_state_t;

endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_i,
  input  logic cs_n_i,
  input  logic si_i,
  output logic sck_rise,
  output logic sck_fall,
  output logic frame_start,
  output logic frame_end,
  output logic si_s
);

  logic [STAGES:0]   sck_p;
  logic [STAGES:0]   cs_p;
  logic [STAGES-1:0] si_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_p <= '0;
      cs_p  <= '1;
      si_p  <= '0;
    end else begin
      sck_p <= {sck_p[STAGES-1:0], sck_i};
      cs_p  <= {cs_p[STAGES-1:0], cs_n_i};
      si_p  <= {si_p[STAGES-2:0], si_i};
    end
  end

  assign sck_rise    =  sck_p[STAGES-1] & ~sck_p[STAGES];
  assign sck_fall    = ~sck_p[STAGES-1] &  sck_p[STAGES];
  assign frame_start = ~cs_p[STAGES-1]  &  cs_p[STAGES];
  assign frame_end   =  cs_p[STAGES-1]  & ~cs_p[STAGES];
  assign si_s        =  si_p[STAGES-1];

endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/spi_ee_page_wr.sv
module spi_ee_page_wr #(
  parameter int AW        = 9,
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 2000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              begin_i,
  input  logic [AW-1:0]     base_i,
  input  logic              push_i,
  input  logic [PAGE_W-1:0] push_idx_i,
  input  logic [7:0]        push_data_i,
  input  logic              commit_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_waddr_o,
  output logic [7:0]        mem_wdata_o
);

  localparam int PAGE  = 1 << PAGE_W;
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  logic [7:0]           pbuf [PAGE];
  logic [PAGE-1:0]      pvalid;
  logic [AW-PAGE_W-1:0] page_q;
  logic [CNT_W-1:0]     cnt;
  logic [PAGE_W-1:0]    cidx;

  assign cidx = cnt[PAGE_W-1:0];

  always_ff @(posedge clk) begin
    if (push_i && !busy_o) pbuf[push_idx_i] <= push_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pvalid      <= '0;
      page_q      <= '0;
      cnt         <= '0;
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_waddr_o <= '0;
      mem_wdata_o <= '0;
    end else begin
      done_o   <= 1'b0;
      mem_we_o <= 1'b0;
      if (!busy_o) begin
        if (begin_i) begin
          pvalid <= '0;
          page_q <= base_i[AW-1:PAGE_W];
        end else if (push_i) begin
          pvalid[push_idx_i] <= 1'b1;
        end
        if (commit_i) begin
          busy_o <= 1'b1;
          cnt    <= '0;
        end
      end else begin
        if (cnt < CNT_W'(PAGE)) begin
          mem_we_o    <= pvalid[cidx];
          mem_waddr_o <= {page_q, cidx};
          mem_wdata_o <= pbuf[cidx];
        end
        cnt <= cnt + 1'b1;
        if (cnt == CNT_W'(WR_CYCLES - 1)) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
          pvalid <= '0;
        end
      end
    end
  end

  // R8: the array is written only inside a write cycle
  a_r8_write_in_cycle: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> busy_o);

  // R5: a commit never arrives while a cycle is already running
  a_r5_commit_when_idle: assert property (@(posedge clk) disable iff (rst)
    commit_i |-> !busy_o);

  // R9: the end pulse marks the falling edge of the busy flag
  a_r9_done_at_end: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o)));

endmodule

// File: rtl/spi_ee_cmd.sv
module spi_ee_cmd
  import spi_ee_pkg::*;
#(
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              frame_start,
  input  logic              frame_end,
  input  logic              si_s,
  input  logic              busy_i,
  input  logic              done_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i,
  output logic              wr_begin_o,
  output logic [ADDR_W-1:0] wr_base_o,
  output logic              wr_push_o,
  output logic [PAGE_W-1:0] wr_idx_o,
  output logic [7:0]        wr_data_o,
  output logic              wr_commit_o,
  output logic              so_o,
  output logic              so_oe_o
);

  fe_state_t         state;
  logic [7:0]        sh;
  logic [2:0]        bcnt;
  logic              a8;
  logic [ADDR_W-1:0] rd_ptr;
  logic              refuse;
  logic [PAGE_W-1:0] widx;
  logic              got_byte;
  logic              wel;
  logic [7:0]        oshift;
  logic [7:0]        byte_in;
  logic              byte_done;
  logic [7:0]        load_byte;

  assign byte_in   = {sh[6:0], si_s};
  assign byte_done = sck_rise && (bcnt == 3'd7);
  assign rd_addr_o = rd_ptr;

  always_comb begin
    if (state == ST_STATUS) load_byte = {6'b0, wel, busy_i};
    else if (refuse)        load_byte = 8'hFF;
    else                    load_byte = rd_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      sh          <= '0;
      bcnt        <= '0;
      a8          <= 1'b0;
      rd_ptr      <= '0;
      refuse      <= 1'b0;
      widx        <= '0;
      got_byte    <= 1'b0;
      wel         <= 1'b0;
      oshift      <= '0;
      so_o        <= 1'b0;
      so_oe_o     <= 1'b0;
      wr_begin_o  <= 1'b0;
      wr_base_o   <= '0;
      wr_push_o   <= 1'b0;
      wr_idx_o    <= '0;
      wr_data_o   <= '0;
      wr_commit_o <= 1'b0;
    end else begin
      wr_begin_o  <= 1'b0;
      wr_push_o   <= 1'b0;
      wr_commit_o <= 1'b0;
      if (done_i) wel <= 1'b0;

      if (frame_start) begin
        state    <= ST_OPC;
        bcnt     <= '0;
        so_oe_o  <= 1'b0;
        got_byte <= 1'b0;
        refuse   <= 1'b0;
      end else if (frame_end) begin
        state   <= ST_IDLE;
        so_oe_o <= 1'b0;
        case (state)
          ST_WEN:     wel <= 1'b1;
          ST_WDI:     wel <= 1'b0;
          ST_WR_DATA: if (got_byte && bcnt == 3'd0 && wel) wr_commit_o <= 1'b1;
          default: ;
        endcase
      end else if (state != ST_IDLE) begin
        if (sck_rise) begin
          sh   <= byte_in;
          bcnt <= bcnt + 3'd1;
          case (state)
            ST_OPC: if (byte_done) begin
              a8 <= byte_in[3];
              if (byte_in[7:4] != 4'h0)            state <= ST_IGNORE;
              else if (byte_in[2:0] == OP_READ_LO)  state <= ST_RD_ADDR;
              else if (byte_in[2:0] == OP_WRITE_LO) state <= busy_i ? ST_IGNORE : ST_WR_ADDR;
              else if (byte_in == OP_WREN)          state <= busy_i ? ST_IGNORE : ST_WEN;
              else if (byte_in == OP_WRDI)          state <= busy_i ? ST_IGNORE : ST_WDI;
              else if (byte_in == OP_RDSR)          state <= ST_STATUS;
              else                                  state <= ST_IGNORE;
            end
            ST_RD_ADDR: if (byte_done) begin
              rd_ptr <= {a8, byte_in};
              refuse <= busy_i;
              state  <= ST_RD_DATA;
            end
            ST_RD_DATA: if (byte_done) rd_ptr <= rd_ptr + 1'b1;
            ST_WR_ADDR: if (byte_done) begin
              wr_base_o  <= {a8, byte_in};
              widx       <= byte_in[PAGE_W-1:0];
              wr_begin_o <= 1'b1;
              state      <= ST_WR_DATA;
            end
            ST_WR_DATA: if (byte_done) begin
              wr_push_o <= 1'b1;
              wr_idx_o  <= widx;
              wr_data_o <= byte_in;
              widx      <= widx + 1'b1;
              got_byte  <= 1'b1;
            end
            ST_WEN, ST_WDI: state <= ST_IGNORE;
            default: ;
          endcase
        end else if (sck_fall && (state == ST_RD_DATA || state == ST_STATUS)) begin
          so_oe_o <= 1'b1;
          if (bcnt == 3'd0) begin
            so_o   <= load_byte[7];
            oshift <= {load_byte[6:0], 1'b0};
          end else begin
            so_o   <= oshift[7];
            oshift <= {oshift[6:0], 1'b0};
          end
        end
      end
    end
  end

  // R1: no drive while the bus is deselected
  a_r1_hiz_idle: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !so_oe_o);

  // R1: drive only in a data-out phase
  a_r1_drive_phase: assert property (@(posedge clk) disable iff (rst)
    so_oe_o |-> (state == ST_RD_DATA || state == ST_STATUS));

  // R4: latch rises only at a frame end that follows a lone enable byte
  a_r4_wel_set: assert property (@(posedge clk) disable iff (rst)
    $rose(wel) |-> ($past(frame_end) && $past(state) == ST_WEN));

  // R3: read pointer rolls over from the top address
  a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
    (byte_done && state == ST_RD_DATA && rd_ptr == '1 && !frame_start && !frame_end)
      |=> (rd_ptr == '0));

  // R8: refused read shifts ones
  a_r8_refused_ones: assert property (@(posedge clk) disable iff (rst)
    (sck_fall && !sck_rise && state == ST_RD_DATA && refuse && !frame_start && !frame_end)
      |=> so_o);

  // R9: end of a write cycle clears the latch
  a_r9_wel_clear: assert property (@(posedge clk) disable iff (rst)
    (done_i && !frame_end) |=> !wel);

endmodule

// File: rtl/spi_ee_target.sv
module spi_ee_target
  import spi_ee_pkg::*;
#(
  parameter int PAGE_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int WR_CYCLES   = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe
);

  logic              sck_rise, sck_fall, frame_start, frame_end, si_s;
  logic              busy, done;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        rd_data;
  logic              wr_begin, wr_push, wr_commit;
  logic [ADDR_W-1:0] wr_base;
  logic [PAGE_W-1:0] wr_idx;
  logic [7:0]        wr_data;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [7:0]        mem_wdata;

  spi_ee_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .sck_i(spi_sck), .cs_n_i(spi_cs_n), .si_i(spi_mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall),
    .frame_start(frame_start), .frame_end(frame_end), .si_s(si_s)
  );

  spi_ee_cmd #(.PAGE_W(PAGE_W)) u_cmd (
    .clk(clk), .rst(rst),
    .sck_rise(sck_rise), .sck_fall(sck_fall),
    .frame_start(frame_start), .frame_end(frame_end), .si_s(si_s),
    .busy_i(busy), .done_i(done),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .wr_begin_o(wr_begin), .wr_base_o(wr_base),
    .wr_push_o(wr_push), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
    .wr_commit_o(wr_commit),
    .so_o(spi_miso), .so_oe_o(spi_miso_oe)
  );

  spi_ee_page_wr #(.AW(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_page (
    .clk(clk), .rst(rst),
    .begin_i(wr_begin), .base_i(wr_base),
    .push_i(wr_push), .push_idx_i(wr_idx), .push_data_i(wr_data),
    .commit_i(wr_commit),
    .busy_o(busy), .done_o(done),
    .mem_we_o(mem_we), .mem_waddr_o(mem_waddr), .mem_wdata_o(mem_wdata)
  );

  spi_ee_array #(.AW(ADDR_W)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );

endmodule

// File: tb/spi_ee_target_test.sv
module spi_ee_target_test;

  localparam int WRC = 2000;
  localparam int HP  = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic miso, miso_oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [7:0] mem_m [512];
  bit wel_m  = 1'b0;
  bit busy_m = 1'b0;

  always #4 clk = ~clk;

  spi_ee_target #(.WR_CYCLES(WRC)) uut (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(miso_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // shift nb bits of tx (MSB first); check drive enable at every sample
  task automatic xfer(input logic [7:0] tx, input int nb, input bit exp_oe,
                      input string req, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      @(negedge clk);
      mosi = tx[i];
      wait_clk(HP - 1);
      rx[i] = miso;
      chk({req, " drive enable"}, {7'b0, miso_oe}, {7'b0, exp_oe});
      @(negedge clk);
      sck = 1'b1;
      wait_clk(HP);
      sck = 1'b0;
    end
  endtask

  task automatic cs_lo();
    @(negedge clk);
    cs_n = 1'b0;
    wait_clk(HP);
  endtask

  task automatic cs_hi();
    wait_clk(HP);
    cs_n = 1'b1;
    wait_clk(4 * HP);
    chk("R1 idle hi-z", {7'b0, miso_oe}, 8'h00);
  endtask

  task automatic rdsr(input string req);
    logic [7:0] rx;
    cs_lo();
    xfer(8'h05, 8, 1'b0, "R1 opcode", rx);
    xfer(8'h00, 8, 1'b1, req, rx);
    chk({req, " status"}, rx, {6'b0, wel_m, busy_m});
    xfer(8'h00, 8, 1'b1, req, rx);
    chk({req, " status repeat R7"}, rx, {6'b0, wel_m, busy_m});
    cs_hi();
  endtask

  task automatic rd(input int addr, input int n, input string req);
    logic [7:0] rx;
    int a;
    a = addr;
    cs_lo();
    xfer({4'b0, addr[8], 3'b011}, 8, 1'b0, "R1 opcode", rx);
    xfer(addr[7:0], 8, 1'b0, "R1 address", rx);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, 8, 1'b1, req, rx);
      chk(req, rx, busy_m ? 8'hFF : mem_m[a]);
      a = (a + 1) % 512;
    end
    cs_hi();
  endtask

  task automatic wren_frame();
    logic [7:0] rx;
    cs_lo();
    xfer(8'h06, 8, 1'b0, "R4 opcode", rx);
    cs_hi();
    if (!busy_m) wel_m = 1'b1;
  endtask

  // full write; model commits when latch set and not busy
  task automatic wr(input int addr, input logic [7:0] d [$]);
    logic [7:0] rx;
    int a;
    cs_lo();
    xfer({4'b0, addr[8], 3'b010}, 8, 1'b0, "R5 opcode", rx);
    xfer(addr[7:0], 8, 1'b0, "R5 address", rx);
    foreach (d[k]) xfer(d[k], 8, 1'b0, "R5 data", rx);
    cs_hi();
    if (wel_m && !busy_m && d.size() > 0) begin
      a = addr;
      foreach (d[k]) begin
        mem_m[a] = d[k];
        a = (a & 9'h1F0) | ((a + 1) & 4'hF);
      end
      busy_m = 1'b1;
    end
  endtask

  task automatic finish_cycle();
    wait_clk(WRC + 50);
    if (busy_m) begin
      busy_m = 1'b0;
      wel_m  = 1'b0;
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] rx;
    logic [7:0] q [$];
    for (int i = 0; i < 512; i++) mem_m[i] = 8'h00;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(5);
    chk("R1 reset hi-z", {7'b0, miso_oe}, 8'h00);
    rdsr("R7 reset status");

    // R4 + R9: enable latch then write page 0
    wren_frame();
    rdsr("R4 latch set");
    q = {8'h11, 8'h22, 8'h33};
    wr(9'h000, q);
    finish_cycle();
    rdsr("R9 latch cleared after cycle");

    // R6 page wrap in top page; R8 behaviour during the cycle
    wren_frame();
    q = {8'hD0, 8'hD1, 8'hD2, 8'hD3, 8'hD4, 8'hD5};
    wr(9'h1FC, q);
    rdsr("R8 status during cycle");
    rd(9'h000, 2, "R8 refused read");
    q = {8'hEE};
    wr(9'h000, q);
    finish_cycle();
    rd(9'h000, 3, "R8 write during cycle ignored");
    rd(9'h1FC, 7, "R3 rollover / R6 page data");
    rd(9'h1F0, 2, "R6 wrapped bytes");

    // R4: enable followed by write in the same frame
    cs_lo();
    xfer(8'h06, 8, 1'b0, "R4 opcode", rx);
    xfer(8'h02, 8, 1'b0, "R4 write", rx);
    xfer(8'h00, 8, 1'b0, "R4 addr", rx);
    xfer(8'h55, 8, 1'b0, "R4 data", rx);
    cs_hi();
    rdsr("R4 no latch after shared frame");
    rd(9'h000, 1, "R4 array untouched");

    // R4: enable followed by extra clocks
    cs_lo();
    xfer(8'h06, 8, 1'b0, "R4 opcode", rx);
    xfer(8'h00, 3, 1'b0, "R4 extra", rx);
    cs_hi();
    rdsr("R4 no latch after extra clocks");

    // R5: write without the latch
    q = {8'h77};
    wr(9'h001, q);
    rdsr("R5 no cycle without latch");
    rd(9'h001, 1, "R5 array untouched");

    // R5: write cut mid-byte; R9 WRDI
    wren_frame();
    cs_lo();
    xfer(8'h02, 8, 1'b0, "R5 opcode", rx);
    xfer(8'h02, 8, 1'b0, "R5 addr", rx);
    xfer(8'h99, 8, 1'b0, "R5 data", rx);
    xfer(8'h90, 4, 1'b0, "R5 partial", rx);
    cs_hi();
    rdsr("R5 partial write no cycle");
    rd(9'h002, 1, "R5 partial write discarded");
    cs_lo();
    xfer(8'h04, 8, 1'b0, "R9 opcode", rx);
    cs_hi();
    wel_m = 1'b0;
    rdsr("R9 disable clears latch");

    // R10: unknown opcode
    cs_lo();
    xfer(8'hA5, 8, 1'b0, "R10 opcode", rx);
    xfer(8'h00, 8, 1'b0, "R10 trailing", rx);
    xfer(8'h00, 8, 1'b0, "R10 trailing", rx);
    cs_hi();
    rdsr("R10 state unchanged");

    // R2: second read of a high address with A8 in the opcode
    rd(9'h1FE, 3, "R2 high address read");

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule